// File: doc/BRIEF.md
# Periodic Timer with Edge Capture

This block is a 10-bit up-counting timer whose period is set by a full-width period value. Each time the next count would equal the period value, the counter returns to zero and the period flag is raised. A second value, the compare-A register, serves two purposes. In the compare and PWM modes it is a match point that raises the A flag. In capture mode it holds the count that was latched when a selected edge arrived on an external input.

Software controls the timer through enable, pause, mode and edge-select fields. It loads the period value and the compare-A value, and it clears the two flags with one-cycle clear strobes. The capture input may be asynchronous. It is passed through a two-stage synchroniser, and edges are detected on the synchronised signal. Capture events never disturb the running counter.

Top module: `periodic_capture_timer`

## Requirements
- R1: While rst_ni is low, cnt_o, cmpa_o, flag_a_o and flag_p_o are all zero.
- R2: When en_i=1 and pause_i=0, cnt_o advances by one per clock unless a period match occurs.
- R3: When en_i=1 and pause_i=1, cnt_o holds its value and is not cleared.
- R4: When en_i=0, cnt_o becomes zero on the next clock and stays at zero.
- R5: When the counter advances and the incremented value equals period_i, cnt_o returns to zero and flag_p_o is set. A period_i of zero gives a full 1024-count cycle.
- R6: The mode field mode_i uses these codes: 00 compare, 01 capture, 10 PWM or single pulse, 11 treated as compare. In any mode other than 01, a write strobe loads cmpa_o from cmpa_wdata_i, and flag_a_o is set when the advancing counter's incremented value equals cmpa_o.
- R7: In capture mode with en_i=1 and edge_sel_i=00, a rising edge of the synchronised capture input stores the current cnt_o into cmpa_o and sets flag_a_o.
- R8: In capture mode, edge_sel_i=01 captures on falling edges and edge_sel_i=10 captures on both edges.
- R9: In capture mode with edge_sel_i=11, no capture happens: cmpa_o and flag_a_o are unchanged by activity on cap_i.
- R10: Timing of a capture. If cap_i changes before clock edge k, the capture takes effect at edge k+2 and stores the cnt_o value held just before that edge. The counter itself continues without interruption.
- R11: In capture mode, software writes to cmpa_o are ignored. The captured value stays stable until the next qualifying edge.
- R12: A clear strobe (clr_a_i or clr_p_i) clears its flag. If the flag is being set in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Counter enable; low clears the counter |
| pause_i | input | 1 | Freeze the counter |
| mode_i | input | 2 | Operating mode |
| edge_sel_i | input | 2 | Capture edge select |
| cap_i | input | 1 | Asynchronous capture input |
| period_i | input | 10 | Period value |
| cmpa_wr_i | input | 1 | Write strobe for compare-A |
| cmpa_wdata_i | input | 10 | Compare-A write data |
| clr_a_i | input | 1 | Clear A flag |
| clr_p_i | input | 1 | Clear P flag |
| cnt_o | output | 10 | Running count |
| cmpa_o | output | 10 | Compare-A / captured value |
| flag_a_o | output | 1 | A match or capture flag |
| flag_p_o | output | 1 | Period match flag |

## Verification
The assertions assume that mode_i and edge_sel_i are held steady from one clock to the next. They also assume that pulses on cap_i last long enough to pass through the synchroniser, so that every edge the checker relies on reaches the detector. The stimulus changes the control fields only at phase boundaries. It toggles cap_i at intervals of many clocks and drives every input on the falling clock edge, so that each change is clean relative to the sampling edge. The reference model follows the same two-stage input delay, so that captured values are compared on every clock.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic [1:0] {
    MODE_CMP = 2'b00,
    MODE_CAP = 2'b01,
    MODE_PWM = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_e;
endpackage

// File: rtl/pct_sync.sv
module pct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;
  // q[0..LAST] synchroniser chain, q[STAGES] previous synchronised value
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-1:0], d_i};
  end

  assign rise_o = q[LAST] & ~q[STAGES];
  assign fall_o = ~q[LAST] & q[STAGES];
endmodule

// File: rtl/pct_counter.sv
module pct_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pause_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmpa_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             p_hit_o,
  output logic             a_hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, nxt;
  logic             step;

  assign step    = en_i & ~pause_i;
  assign nxt     = cnt_q + ONE;
  assign p_hit_o = step & (nxt == period_i);
  assign a_hit_o = step & (nxt == cmpa_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (p_hit_o) cnt_q <= '0;
    else if (step)    cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pct_capture.sv
module pct_capture
  import pct_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             a_hit_i,
  input  logic             p_hit_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             clr_a_i,
  input  logic             clr_p_i,
  output logic [CNT_W-1:0] cmpa_o,
  output logic             flag_a_o,
  output logic             flag_p_o
);
  logic is_cap, edge_ok, cap_evt, a_set;

  assign is_cap = (mode_i == MODE_CAP);

  always_comb begin
    unique case (edge_e'(edge_sel_i))
      EDGE_RISE: edge_ok = rise_i;
      EDGE_FALL: edge_ok = fall_i;
      EDGE_BOTH: edge_ok = rise_i | fall_i;
      default:   edge_ok = 1'b0;
    endcase
  end

  assign cap_evt = en_i & is_cap & edge_ok;
  assign a_set   = is_cap ? cap_evt : a_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cmpa_o <= '0;
    else if (cap_evt)          cmpa_o <= cnt_i;
    else if (wr_i && !is_cap)  cmpa_o <= wdata_i;
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_a_o <= 1'b0;
      flag_p_o <= 1'b0;
    end else begin
      if (a_set)        flag_a_o <= 1'b1;
      else if (clr_a_i) flag_a_o <= 1'b0;
      if (p_hit_i)      flag_p_o <= 1'b1;
      else if (clr_p_i) flag_p_o <= 1'b0;
    end
  end
endmodule

// File: rtl/periodic_capture_timer.sv
module periodic_capture_timer #(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pause_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             cmpa_wr_i,
  input  logic [CNT_W-1:0] cmpa_wdata_i,
  input  logic             clr_a_i,
  input  logic             clr_p_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmpa_o,
  output logic             flag_a_o,
  output logic             flag_p_o
);
  logic rise, fall, p_hit, a_hit;

  pct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cap_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  pct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .pause_i  (pause_i),
    .period_i (period_i),
    .cmpa_i   (cmpa_o),
    .cnt_o    (cnt_o),
    .p_hit_o  (p_hit),
    .a_hit_o  (a_hit)
  );

  pct_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .mode_i     (mode_i),
    .edge_sel_i (edge_sel_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .cnt_i      (cnt_o),
    .a_hit_i    (a_hit),
    .p_hit_i    (p_hit),
    .wr_i       (cmpa_wr_i),
    .wdata_i    (cmpa_wdata_i),
    .clr_a_i    (clr_a_i),
    .clr_p_i    (clr_p_i),
    .cmpa_o     (cmpa_o),
    .flag_a_o   (flag_a_o),
    .flag_p_o   (flag_p_o)
  );
endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pause_i,
  input logic [1:0]       mode_i,
  input logic [1:0]       edge_sel_i,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cmpa_o,
  input logic             flag_a_o,
  input logic             flag_p_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] nxt_c;
  assign nxt_c = cnt_o + ONE;

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pause_i && nxt_c != period_i) |=> cnt_o == $past(nxt_c));
  // R3
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pause_i) |=> $stable(cnt_o));
  // R4
  disabled_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_o == '0);
  // R5 R12
  period_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pause_i && nxt_c == period_i) |=> (cnt_o == '0) && flag_p_o);
  // R9
  cap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && edge_sel_i == 2'b11) |=> $stable(cmpa_o) && !$rose(flag_a_o));
  // R11
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'b01 && !$stable(cmpa_o)) |-> flag_a_o);
endmodule

bind periodic_capture_timer pct_checker #(.CNT_W(CNT_W)) u_pct_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .pause_i    (pause_i),
  .mode_i     (mode_i),
  .edge_sel_i (edge_sel_i),
  .period_i   (period_i),
  .cnt_o      (cnt_o),
  .cmpa_o     (cmpa_o),
  .flag_a_o   (flag_a_o),
  .flag_p_o   (flag_p_o)
);

// File: tb/periodic_capture_timer_bench.sv
module periodic_capture_timer_bench;
  localparam int W   = 10;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pause = 1'b0, cap = 1'b0, wr = 1'b0, clr_a = 1'b0, clr_p = 1'b0;
  logic [1:0] mode = 2'b00, esel = 2'b00;
  logic [W-1:0] period = '0, wdata = '0;
  logic [W-1:0] cnt, cmpa;
  logic fa, fp;

  int errors = 0;
  int checks = 0;
  string tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  periodic_capture_timer u_periodic_capture_timer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pause_i(pause), .mode_i(mode),
    .edge_sel_i(esel), .cap_i(cap), .period_i(period), .cmpa_wr_i(wr),
    .cmpa_wdata_i(wdata), .clr_a_i(clr_a), .clr_p_i(clr_p),
    .cnt_o(cnt), .cmpa_o(cmpa), .flag_a_o(fa), .flag_p_o(fp)
  );

  // behavioural reference model
  int m_cnt, m_a, m_fa, m_fp;
  int s1, s2, s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_a = 0; m_fa = 0; m_fp = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int nx, old_cnt, old_a;
      bit rise, fall, hit_ok, aset, pset, stepping;
      rise = (s2 == 1) && (s3 == 0);
      fall = (s2 == 0) && (s3 == 1);
      s3 = s2; s2 = s1; s1 = int'(cap);
      old_cnt = m_cnt; old_a = m_a;
      stepping = en && !pause;
      nx = (old_cnt + 1) % MOD;
      pset = stepping && (nx == int'(period));
      if (!en) m_cnt = 0;
      else if (pset) m_cnt = 0;
      else if (stepping) m_cnt = nx;
      case (esel)
        2'b00: hit_ok = rise;
        2'b01: hit_ok = fall;
        2'b10: hit_ok = rise || fall;
        default: hit_ok = 0;
      endcase
      if (mode == 2'b01) begin
        aset = en && hit_ok;
        if (aset) m_a = old_cnt;
      end else begin
        aset = stepping && (nx == old_a);
        if (wr) m_a = int'(wdata);
      end
      if (aset) m_fa = 1; else if (clr_a) m_fa = 0;
      if (pset) m_fp = 1; else if (clr_p) m_fp = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(cnt) != m_cnt || int'(cmpa) != m_a || int'(fa) != m_fa || int'(fp) != m_fp) begin
        errors++;
        $display("FAIL %s: cnt=%0d cmpa=%0d fa=%0d fp=%0d expected cnt=%0d cmpa=%0d fa=%0d fp=%0d",
                 tag, cnt, cmpa, fa, fp, m_cnt, m_a, m_fa, m_fp);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_cap(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i % gap == 0) cap = ~cap;
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired in %s", tag);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    run(3);
    checks++;
    if (cnt != 0 || cmpa != 0 || fa || fp) begin
      errors++;
      $display("FAIL R1: cnt=%0d cmpa=%0d fa=%0d fp=%0d expected all 0", cnt, cmpa, fa, fp);
    end
    rst_n = 1'b1;
    run(2);

    // R2 R5 R6 compare mode counting, period and A match
    tag = "R6"; mode = 2'b00; wr = 1; wdata = 10'd7; period = 10'd20;
    run(1); wr = 0; en = 1;
    tag = "R2"; run(30);
    tag = "R5"; run(30);
    clr_a = 1; clr_p = 1; run(1); clr_a = 0; clr_p = 0;
    // R12 clear held high: flags only pulse on set cycles
    tag = "R12"; clr_a = 1; clr_p = 1; run(45); clr_a = 0; clr_p = 0;

    // R3 pause
    tag = "R3"; pause = 1; run(10); pause = 0; run(5);
    // R4 disable
    tag = "R4"; en = 0; run(6); en = 1;
    // R5 full-range period
    tag = "R5"; period = 10'd0; run(1100);

    // R6 PWM code and reserved code behave as compare
    tag = "R6"; mode = 2'b10; period = 10'd50; wr = 1; wdata = 10'd33; run(1); wr = 0; run(120);
    mode = 2'b11; run(60);

    // capture modes
    period = 10'd300; mode = 2'b01;
    tag = "R7";  esel = 2'b00; toggle_cap(200, 13);
    tag = "R10"; toggle_cap(100, 29);
    tag = "R8";  esel = 2'b01; toggle_cap(150, 17);
    esel = 2'b10; toggle_cap(150, 11);
    tag = "R9";  esel = 2'b11; toggle_cap(100, 7);
    tag = "R11"; esel = 2'b00; wr = 1; wdata = 10'd999; toggle_cap(80, 37); wr = 0;
    clr_a = 1; run(1); clr_a = 0;
    tag = "R12"; clr_a = 1; toggle_cap(60, 9); clr_a = 0;
    tag = "R4"; en = 0; toggle_cap(30, 5); en = 1; run(5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule